// File: doc/BRIEF.md
# Register Block Transfer Engine

This block carries out the two bulk-move instructions of an 8-bit virtual processor. On a start strobe it receives the instruction's low opcode byte, the highest register number X, the current index value I and a flag that chooses the index update rule. The store form writes registers V0 to VX into byte memory at I, I+1 and onward. The load form reads the same span of memory into V0 to VX.

The engine moves one byte per cycle. It drives a byte-wide synchronous memory port whose read data arrives one cycle after the address. It also drives the register file's read port, which has combinational read data, and its write port. When the last byte has landed, the engine pulses a done flag. In the same cycle it presents the index value the next instruction must use.

Top module: `bte_engine`

## Requirements
- R1: A start with opcode byte 0x55 (store) writes register k to memory address I+k for every k from 0 to X, in ascending order of k, one write per cycle.
- R2: A start with opcode byte 0x65 (load) writes the byte read from address I+k into register k for every k from 0 to X, in ascending order of k, one write per cycle.
- R3: A start whose opcode byte is neither 0x55 nor 0x65 is ignored: busy stays low and no memory or register write follows.
- R4: Exactly X+1 bytes move. Registers above X and memory addresses outside I..I+X receive no write.
- R5: Memory addresses are 12 bits and I+k wraps modulo 4096.
- R6: If start is sampled at clock edge 0, done is high during the (X+2)-th cycle after that edge for a store and during the (X+3)-th cycle for a load.
- R7: Done is high for exactly one cycle per accepted transfer. Busy is high from the cycle after acceptance until the last byte is written, and low in the done cycle.
- R8: With the advance flag set, the index output equals (I+X+1) mod 4096 in the done cycle.
- R9: With the advance flag clear, the index output equals the I given at start in the done cycle.
- R10: A start received while busy is high is ignored and does not disturb the running transfer.
- R11: While reset is asserted and right after it is released, busy, done and both write enables are low and the index output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| op_i | input | 8 | Low opcode byte choosing the direction |
| last_idx_i | input | 4 | Highest register number X to move |
| base_i | input | 12 | Index value I at start |
| advance_i | input | 1 | 1: index output advances by X+1; 0: index unchanged |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| idx_o | output | 12 | Index value after the last transfer |
| mem_addr_o | output | 12 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read data, one cycle after address |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 8 | Register file read data, combinational |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 8 | Register file write data |
| rf_we_o | output | 1 | Register file write enable |

## Verification
The bench builds the engine with its default parameters: a 12-bit address, 8-bit data and sixteen registers. With these values a full sixteen-register move (X=15) fits easily into a short run. Index values close to 4095 then cross the top of the address space, so the wrap of both the write addresses and the advanced index can be observed at the ports. The one-cycle read latency of a real memory is modelled in the bench, so the load pipeline is exercised against true timing.

// File: rtl/bte_pkg.sv
package bte_pkg;
  localparam logic [7:0] OP_STORE = 8'h55;
  localparam logic [7:0] OP_LOAD  = 8'h65;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MOVE  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } bte_state_e;
endpackage

// File: rtl/bte_decode.sv
module bte_decode
  import bte_pkg::*;
(
  input  logic [7:0] op_i,
  output logic       hit_o,
  output logic       load_o
);
  always_comb begin
    hit_o  = 1'b0;
    load_o = 1'b0;
    case (op_i)
      OP_STORE: hit_o = 1'b1;
      OP_LOAD: begin
        hit_o  = 1'b1;
        load_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bte_ctrl.sv
module bte_ctrl
  import bte_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             load_i,
  input  logic [IDX_W-1:0] last_i,
  output bte_state_e       state_o,
  output logic [IDX_W-1:0] cnt_o,
  output logic [IDX_W-1:0] last_o,
  output logic             load_o,
  output logic             accept_o,
  output logic             finish_o
);
  bte_state_e       state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] last_q;
  logic             load_q;
  logic             at_end;
  logic             cnt_en;

  assign at_end   = (cnt_q == last_q);
  assign accept_o = req_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign finish_o = ((state_q == ST_MOVE) && at_end && !load_q) ||
                    (state_q == ST_DRAIN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        state_d = accept_o ? ST_MOVE : ST_IDLE;
        if (accept_o) begin
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      ST_MOVE: begin
        if (at_end) begin
          state_d = load_q ? ST_DRAIN : ST_DONE;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_DRAIN: state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      last_q  <= '0;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (accept_o) begin
        last_q <= last_i;
        load_q <= load_i;
      end
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign last_o  = last_q;
  assign load_o  = load_q;
endmodule

// File: rtl/bte_addr.sv
module bte_addr #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              finish_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              advance_i,
  input  logic [IDX_W-1:0]  cnt_i,
  input  logic [IDX_W-1:0]  last_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] idx_o
);
  localparam int PAD_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] base_q;
  logic              adv_q;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [ADDR_W-1:0] cnt_ext, last_ext;

  assign cnt_ext    = {{PAD_W{1'b0}}, cnt_i};
  assign last_ext   = {{PAD_W{1'b0}}, last_i};
  assign mem_addr_o = base_q + cnt_ext;

  always_comb begin
    idx_d = base_q;
    if (adv_q) idx_d = base_q + last_ext + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      adv_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      if (accept_i) begin
        base_q <= base_i;
        adv_q  <= advance_i;
      end
      if (finish_i) idx_q <= idx_d;
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/bte_rdpipe.sv
module bte_rdpipe #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              we_o,
  output logic [IDX_W-1:0]  waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic             pend_q;
  logic [IDX_W-1:0] pidx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pidx_q <= '0;
    end else begin
      pend_q <= issue_i;
      if (issue_i) pidx_q <= idx_i;
    end
  end

  assign we_o    = pend_q;
  assign waddr_o = pidx_q;
  assign wdata_o = rdata_i;
endmodule

// File: rtl/bte_engine.sv
module bte_engine
  import bte_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        op_i,
  input  logic [IDX_W-1:0]  last_idx_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              advance_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [IDX_W-1:0]  rf_raddr_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic [IDX_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              rf_we_o
);
  logic             op_hit, op_load;
  bte_state_e       state;
  logic [IDX_W-1:0] cnt, last;
  logic             load_q, accept, finish;
  logic             moving;

  bte_decode u_dec (
    .op_i   (op_i),
    .hit_o  (op_hit),
    .load_o (op_load)
  );

  bte_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (start_i && op_hit),
    .load_i   (op_load),
    .last_i   (last_idx_i),
    .state_o  (state),
    .cnt_o    (cnt),
    .last_o   (last),
    .load_o   (load_q),
    .accept_o (accept),
    .finish_o (finish)
  );

  bte_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .finish_i   (finish),
    .base_i     (base_i),
    .advance_i  (advance_i),
    .cnt_i      (cnt),
    .last_i     (last),
    .mem_addr_o (mem_addr_o),
    .idx_o      (idx_o)
  );

  assign moving = (state == ST_MOVE);

  bte_rdpipe #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue_i (moving && load_q),
    .idx_i   (cnt),
    .rdata_i (mem_rdata_i),
    .we_o    (rf_we_o),
    .waddr_o (rf_waddr_o),
    .wdata_o (rf_wdata_o)
  );

  assign mem_we_o    = moving && !load_q;
  assign mem_wdata_o = rf_rdata_i;
  assign rf_raddr_o  = cnt;
  assign busy_o      = moving || (state == ST_DRAIN);
  assign done_o      = (state == ST_DONE);
endmodule

// File: rtl/bte_engine_chk.sv
module bte_engine_chk #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] idx_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic [IDX_W-1:0]  rf_waddr_o,
  input logic              rf_we_o
);
  p_we_in_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  p_rf_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> $past(busy_o));

  p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && rf_we_o));

  p_store_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));

  p_load_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && $past(rf_we_o)) |-> (rf_waddr_o == IDX_W'($past(rf_waddr_o) + 1'b1)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(idx_o));

  p_busy_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind bte_engine bte_engine_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .idx_o      (idx_o),
  .mem_addr_o (mem_addr_o),
  .mem_we_o   (mem_we_o),
  .rf_waddr_o (rf_waddr_o),
  .rf_we_o    (rf_we_o)
);

// File: tb/bte_engine_bench.sv
module bte_engine_bench;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int IW = 4;
  localparam int MSZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [7:0]    op_i = '0;
  logic [IW-1:0] last_idx_i = '0;
  logic [AW-1:0] base_i = '0;
  logic          advance_i = 1'b0;
  logic          busy_o, done_o, mem_we_o, rf_we_o;
  logic [AW-1:0] idx_o, mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i, rf_rdata_i, rf_wdata_o;
  logic [IW-1:0] rf_raddr_o, rf_waddr_o;

  logic [DW-1:0] mem [MSZ];
  logic [DW-1:0] rf [16];

  int checks = 0;
  int errors = 0;
  int q_kind[$];
  int q_addr[$];
  int q_data[$];

  always #10 clk = ~clk;

  bte_engine u_bte_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .last_idx_i(last_idx_i), .base_i(base_i), .advance_i(advance_i),
    .busy_o(busy_o), .done_o(done_o), .idx_o(idx_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
    .mem_rdata_i(mem_rdata_i), .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .rf_we_o(rf_we_o)
  );

  // memory with one-cycle read latency, register file with combinational read
  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    mem_rdata_i <= mem[mem_addr_o];
    if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
  end
  assign rf_rdata_i = rf[rf_raddr_o];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: every write or done pulse must match the queue front
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we_o) begin
        if (q_kind.size() == 0 || q_kind[0] != 0) chk(1'b0, "R4 unexpected memory write", int'(mem_addr_o), -1);
        else begin
          chk(int'(mem_addr_o) == q_addr[0] && int'(mem_wdata_o) == q_data[0], "R1 store addr/data",
              int'({mem_addr_o, mem_wdata_o}), (q_addr[0] << 8) | q_data[0]);
          void'(q_kind.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
        end
      end
      if (rf_we_o) begin
        if (q_kind.size() == 0 || q_kind[0] != 1) chk(1'b0, "R4 unexpected register write", int'(rf_waddr_o), -1);
        else begin
          chk(int'(rf_waddr_o) == q_addr[0] && int'(rf_wdata_o) == q_data[0], "R2 load index/data",
              int'({rf_waddr_o, rf_wdata_o}), (q_addr[0] << 8) | q_data[0]);
          void'(q_kind.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
        end
      end
      if (done_o) begin
        if (q_kind.size() == 0 || q_kind[0] != 2) chk(1'b0, "R7 unexpected done", 1, 0);
        else begin
          chk(int'(idx_o) == q_data[0], (q_addr[0] != 0) ? "R8 advanced index" : "R9 held index",
              int'(idx_o), q_data[0]);
          void'(q_kind.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
        end
      end
    end
  end

  // driver: pushes expected items, drives start, measures latency
  task automatic run_xfer(input logic [7:0] op, input int x, input int base, input bit adv, input bit poke);
    bit is_load = (op == 8'h65);
    int n = 0;
    for (int k = 0; k <= x; k++) begin
      q_kind.push_back(is_load ? 1 : 0);
      q_addr.push_back(is_load ? k : ((base + k) % MSZ));
      q_data.push_back(is_load ? int'(mem[(base + k) % MSZ]) : int'(rf[k]));
    end
    q_kind.push_back(2);
    q_addr.push_back(adv ? 1 : 0);
    q_data.push_back(adv ? ((base + x + 1) % MSZ) : base);
    @(negedge clk);
    start_i = 1'b1; op_i = op; last_idx_i = IW'(x); base_i = AW'(base); advance_i = adv;
    @(negedge clk); n++;
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R7 busy after accept", int'(busy_o), 1);
    if (poke) begin
      @(negedge clk); n++;
      start_i = 1'b1; op_i = 8'h55; last_idx_i = 4'hF; base_i = 12'h000; advance_i = 1'b1;
      @(negedge clk); n++;
      start_i = 1'b0;
    end
    while (!done_o && n < x + 10) begin
      @(negedge clk); n++;
    end
    chk(n == x + (is_load ? 3 : 2), "R6 done latency", n, x + (is_load ? 3 : 2));
    chk(busy_o == 1'b0, "R7 busy low in done cycle", int'(busy_o), 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done single pulse", int'(done_o), 0);
    repeat (2) @(negedge clk);
    chk(q_kind.size() == 0, "R4 all expected writes seen", q_kind.size(), 0);
  endtask

  task automatic bad_op(input logic [7:0] op);
    @(negedge clk);
    start_i = 1'b1; op_i = op; last_idx_i = 4'h7; base_i = 12'h040; advance_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b0, "R3 unknown opcode ignored", int'(busy_o), 0);
    repeat (20) @(negedge clk);
    chk(done_o == 1'b0 && idx_o == 12'h002, "R3 no completion and index kept", int'(idx_o), 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    for (int i = 0; i < MSZ; i++) mem[i] = DW'(i * 7 + 3);
    for (int k = 0; k < 16; k++) rf[k] = DW'(8'hA0 + k);
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_we_o && !rf_we_o && idx_o == '0, "R11 reset state",
        int'({busy_o, done_o, mem_we_o, rf_we_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && idx_o == '0, "R11 state after release", int'(idx_o), 0);

    run_xfer(8'h55, 3, 12'h100, 1'b1, 1'b0);   // R1 R8
    run_xfer(8'h55, 0, 12'h200, 1'b0, 1'b0);   // R4 R9 single byte
    run_xfer(8'h65, 15, 12'h100, 1'b1, 1'b0);  // R2 full file
    for (int k = 0; k < 16; k++) rf[k] = DW'(8'h30 + 3 * k);
    run_xfer(8'h65, 2, 12'h300, 1'b0, 1'b0);   // R2 R9
    run_xfer(8'h55, 3, 12'hFFE, 1'b1, 1'b0);   // R5 store wrap
    run_xfer(8'h65, 5, 12'hFFC, 1'b1, 1'b0);   // R5 load wrap
    bad_op(8'h75);                              // R3
    bad_op(8'h56);                              // R3
    run_xfer(8'h55, 6, 12'h500, 1'b0, 1'b1);   // R10 start while busy
    run_xfer(8'h65, 8, 12'h7F0, 1'b1, 1'b1);   // R10 start while busy, load
    chk(rf[9] == 8'h30 + 27 && rf[15] == 8'h30 + 45, "R4 registers above X untouched",
        int'(rf[9]), 8'h30 + 27);
    chk(mem[12'h507] == DW'(12'h507 * 7 + 3), "R4 memory past I+X untouched",
        int'(mem[12'h507]), int'(DW'(12'h507 * 7 + 3)));
    finish_sim();
  end
endmodule